// File: doc/BRIEF.md
# Serial Frequency-Synthesizer Loader

This block loads a control word into an external frequency synthesizer over two wires, one carrying data and one carrying a clock, both driven one step at a time. A single-cycle `start` with the word on `word` begins a transfer. The block first sends an unlock preamble. It then sends a start bit and the word, least significant bit first. Each bit is sent twice: inverted, then true, so the receiver can check it. A stop pattern follows. In the final step the pins go back to the levels they had when the transfer began.

While no transfer is running, the two pins follow the static levels on `idle_data` and `idle_clk`. These inputs carry the frequency-select value that the two shared wires hold in normal operation. Every pin state during a transfer is held for `STEP_CYCLES` system clocks. The block raises `done` for one cycle when the transfer is over.

Top module: `synth_prog_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `busy` and `done`, and aborts any running transfer. While not busy, the pins show the idle inputs.
- R2: While `busy` is low, `pin_data` equals `idle_data` and `pin_clk` equals `idle_clk`. When `start` is sampled high with `busy` low, `busy` is high from the next cycle. The word and the idle levels are captured at that edge.
- R3: Step 0 drives data 1 and clock 0. Steps 1 to 10 give five clock pulses with data held at 1. Odd steps drive clock 0 and even steps drive clock 1.
- R4: After the preamble come four steps with data 0 and clock 0, 1, 0, 1. The first pair closes the preamble and the second pair is the start bit.
- R5: The word's bits follow, least significant bit first, four steps per bit b. The steps drive (data, clock) = (~b,1), (~b,0), (b,0), (b,1).
- R6: The stop pattern is (1,1), (1,0), (1,1). With `EXTRA_HOLD`=1, a further (1,1) step follows as a delay.
- R7: The last step of a transfer drives the idle levels captured at start, even if the idle inputs have changed since.
- R8: Every step holds its pin state for exactly `STEP_CYCLES` clocks, with no change in between.
- R9: A `start` sampled while `busy` is high is ignored. The running transfer and its captured word and levels are unaffected.
- R10: `done` is high for exactly one cycle. That cycle follows the last step, and `busy` is low in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when not busy |
| word | input | WORD_BITS | Control word to send |
| idle_data | input | 1 | Data level driven while idle |
| idle_clk | input | 1 | Clock level driven while idle |
| pin_data | output | 1 | Serial data wire |
| pin_clk | output | 1 | Serial clock wire |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Step k of a transfer accepted at edge E0 is visible from edge E0+k·STEP_CYCLES for STEP_CYCLES cycles. `done` appears in the cycle after the last step ends. The bench samples on falling edges. It compares every cycle of every transfer against a step number it computes as the cycle count divided by the step length. Because of this, a shortened or lengthened step shows up as a mismatch at the exact cycle where it happens. The bench also changes the idle inputs and pulses `start` in the middle of a transfer. It then checks the restore step against the levels captured at the start, and checks the cycle after `done` against the new idle levels.

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int WORD_BITS   = 24,
  parameter int PULSES      = 5,
  parameter int STEP_CYCLES = 2,
  parameter int EXTRA_HOLD  = 0
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [WORD_BITS-1:0] word,
  input  logic                 idle_data,
  input  logic                 idle_clk,
  output logic                 pin_data,
  output logic                 pin_clk,
  output logic                 busy,
  output logic                 done
);
  localparam int PRE = 1 + 2 * PULSES;
  localparam int DB  = PRE + 4;
  localparam int SB  = DB + 4 * WORD_BITS;
  localparam int RB  = SB + 3 + EXTRA_HOLD;
  localparam int IW  = $clog2(RB + 1);
  localparam int CW  = $clog2(STEP_CYCLES + 1);
  localparam logic [IW-1:0] PRE_I = IW'(PRE);
  localparam logic [IW-1:0] DB_I  = IW'(DB);
  localparam logic [IW-1:0] SB_I  = IW'(SB);
  localparam logic [IW-1:0] SB1_I = IW'(SB + 1);
  localparam logic [IW-1:0] RB_I  = IW'(RB);

  logic [CW-1:0]        cnt_q;
  logic [IW-1:0]        idx_q;
  logic [WORD_BITS-1:0] word_q;
  logic [1:0]           save_q, pat, o_db;
  logic                 step_end, in_data;

  assign step_end = cnt_q == CW'(STEP_CYCLES - 1);
  assign o_db     = idx_q[1:0] - DB_I[1:0];
  assign in_data  = idx_q >= DB_I && idx_q < SB_I;

  always_comb begin
    if (idx_q == '0)        pat = 2'b10;
    else if (idx_q < PRE_I) pat = {1'b1, ~idx_q[0]};
    else if (idx_q < DB_I)  pat = {1'b0, ~idx_q[0]};
    else if (in_data) begin
      case (o_db)
        2'd0:    pat = {~word_q[0], 1'b1};
        2'd1:    pat = {~word_q[0], 1'b0};
        2'd2:    pat = { word_q[0], 1'b0};
        default: pat = { word_q[0], 1'b1};
      endcase
    end
    else if (idx_q < RB_I)  pat = {1'b1, idx_q != SB1_I};
    else                    pat = save_q;
  end

  assign pin_data = busy ? pat[1] : idle_data;
  assign pin_clk  = busy ? pat[0] : idle_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt_q  <= '0;
          idx_q  <= '0;
          word_q <= word;
          save_q <= {idle_data, idle_clk};
        end
      end else if (!step_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (idx_q == RB_I) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
        if (in_data && o_db == 2'd3) word_q <= word_q >> 1;
      end
    end
  end
endmodule

module synth_prog_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       pin_data,
  input logic       pin_clk,
  input logic       mid_step,
  input logic [1:0] save_q
);
  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> (!busy && !done));
  assert_first_step_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (pin_data && !pin_clk));
  assert_step_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && mid_step) |-> $stable({pin_data, pin_clk}));
  assert_capture_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(save_q));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_at_end_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);
endmodule

bind synth_prog_seq synth_prog_seq_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .pin_data(pin_data), .pin_clk(pin_clk),
  .mid_step(cnt_q != '0), .save_q(save_q)
);

// File: tb/synth_prog_seq_tb.sv
module synth_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 3;
  localparam int NSTEPS = 1 + 10 + 4 + 4 * 24 + 4 + 1;

  logic clk = 1'b0, rst, start, idle_data, idle_clk;
  logic [23:0] word;
  logic pin_data, pin_clk, busy, done;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  synth_prog_seq #(.WORD_BITS(24), .PULSES(5), .STEP_CYCLES(STEP), .EXTRA_HOLD(1)) dut_i (
    .clk(clk), .rst(rst), .start(start), .word(word), .idle_data(idle_data),
    .idle_clk(idle_clk), .pin_data(pin_data), .pin_clk(pin_clk), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_pins(input int k, input logic [23:0] w, input logic [1:0] sv);
    int j;
    logic b;
    if (k == 0) return 2'b10;
    if (k <= 10) return {1'b1, (k % 2 == 0)};
    if (k <= 14) return {1'b0, (k == 12 || k == 14)};
    if (k < 111) begin
      j = k - 15;
      b = w[j / 4];
      case (j % 4)
        0: return {~b, 1'b1};
        1: return {~b, 1'b0};
        2: return {b, 1'b0};
        default: return {b, 1'b1};
      endcase
    end
    if (k == 112) return 2'b10;
    if (k < 115) return 2'b11;
    return sv;
  endfunction

  function automatic string req_of(input int k);
    if (k <= 10) return "R3";
    if (k <= 14) return "R4";
    if (k < 111) return "R5";
    if (k < 115) return "R6";
    return "R7";
  endfunction

  task automatic xfer(input logic [23:0] w, input logic [1:0] iv, input bit poke);
    logic [1:0] e;
    {idle_data, idle_clk} = iv;
    word = w;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    word = ~w;
    for (int c = 0; c < NSTEPS * STEP; c++) begin
      if (c > 0) @(negedge clk);
      e = exp_pins(c / STEP, w, iv);
      check(busy === 1'b1 && {pin_data, pin_clk} === e, req_of(c / STEP),
            {busy, pin_data, pin_clk}, {1'b1, e});
      if (poke && c == 40) begin
        start = 1'b1;
        {idle_data, idle_clk} = ~iv;
      end
      if (poke && c == 41) start = 1'b0;
    end
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0, "R10", {done, busy}, 2'b10);
    check({pin_data, pin_clk} === {idle_data, idle_clk}, "R2",
          {pin_data, pin_clk}, {idle_data, idle_clk});
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R10 R9", {done, busy}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b1; word = 24'h0; idle_data = 1'b0; idle_clk = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", {busy, done}, 2'b00);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check({pin_data, pin_clk} === 2'b01, "R2", {pin_data, pin_clk}, 2'b01);
    xfer(24'h000000, 2'b00, 1'b0);
    xfer(24'hFFFFFF, 2'b11, 1'b0);
    xfer(24'hA5A5A5, 2'b01, 1'b1);
    xfer(24'h5A5A5A, 2'b10, 1'b1);
    xfer(24'h123456, 2'b00, 1'b1);
    for (int i = 0; i < 24; i++) xfer(24'h1 << i, 2'(i % 4), (i % 3 == 0));
    xfer(24'hFFFFFE, 2'b11, 1'b0);
    {idle_data, idle_clk} = 2'b11;
    word = 24'h0F0F0F;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    check(busy === 1'b1, "R2", busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && done === 1'b0 && {pin_data, pin_clk} === 2'b11, "R1",
          {busy, done, pin_data, pin_clk}, 4'b0011);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", {busy, done}, 2'b00);
    xfer(24'hC3C3C3, 2'b10, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule